// File: doc/BRIEF.md
# Cartridge Disk Controller Sequencer

A byte-wide front end for a cartridge disk controller. A host issues five kinds of operation on one narrow port: drive select, data read, data write, status sense and output command. The block keeps a command code, a status byte, a head/sector address, a one-byte data buffer and the selected unit. A block-transfer DMA channel moves sector data through the block. Completion is signalled by a one-cycle interrupt that cannot be masked. On an error, completion also pulses a stop request toward the channel.

The data read and data write operations have two meanings. While the controller is idle, a read returns the sector currently under the heads, taken from a free-running rotation counter, and a write loads the head/sector address. During a command, the same operations move bytes through the data buffer and mark the controller busy. Each sector is serviced one rotation period after the command, or after the previous sector. A read sector delivers zeros where the medium supplies no byte. A write sector ends early when the channel signals its last byte, and the rest of the sector is padded with copies of that byte. Address validation is done outside the block and arrives as fault flags that abort the transfer.

Top module: `disk_seq`

## Requirements
- R1: After reset, or after a command with bit 3 (0x08) set, sensed status is 0x0A (busy 0x08 plus idle 0x02). Selected unit, platter, head/sector address and data buffer are all zero.
- R2: Sensed status bits are overrun 0x80, compare fail 0x40, defective track 0x20, cylinder overflow 0x10, busy 0x08, examine 0x04, idle 0x02 and transfer error 0x01. Examine reads 1 exactly when any of bits 7..4 is 1.
- R3: While idle, a data read returns the rotation sector, which advances once every ROT_PERIOD cycles and wraps modulo SECTORS (24). While idle, a data write loads hs_addr from data bits 5..0.
- R4: A command with bit 3 clear is ignored, leaving status unchanged, when the idle bit is clear or the drive_busy bit of the selected unit is set.
- R5: An accepted command with low code 2 (write) sets status to 0x00. Any other accepted code sets status to 0x08. Only codes 1 (read), 2 (write) and 3 (read check) start a sequence. Other codes leave the controller non-idle with no completion.
- R6: A started command is serviced ROT_PERIOD cycles after acceptance. At service, the error flags are formed from addr_fault[3:0], which maps to status bits 7..4, and from the transfer error bit 0, which is drive_fault OR (write AND drive_wprot). Read check completes at service with these flags. Read and write complete at service with these flags if any is set.
- R7: A read sector presents SECTOR_BYTES bytes on dma_rdata with dma_rvalid high. Each byte is disk_rdata when disk_rvalid is high, and zero otherwise.
- R8: A write sector forwards channel bytes to disk_wdata. After the byte marked by dma_wend, the remaining bytes up to SECTOR_BYTES repeat that last byte.
- R9: If dma_active is high when a sector ends, the next sector is serviced ROT_PERIOD cycles later. Each finished sector advances hs_addr. Sector 23 wraps to sector 0 and toggles the head bit (bit 5).
- R10: Completion clears busy, sets idle, ORs in the error flags and pulses irq for one cycle. dma_stop pulses together with irq exactly when an error flag is set.
- R11: If dma_active is low when a read or write is serviced, transfer error is set and the command completes without dma_stop.
- R12: While not idle, a data write stores the byte in the data buffer and sets busy. A data read returns the data buffer and sets busy.
- R13: A select operation is accepted only while idle. It latches the unit from data bits 1..0 and the platter from bit 7. The platter output takes the latched platter when a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_op | input | 3 | Host operation: 0 none, 1 select, 2 data read, 3 data write, 4 sense, 5 command |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (data read or sense) |
| drive_busy | input | NDRV | Per-drive busy (seeking) |
| sel_unit | output | UW | Latched drive unit |
| platter | output | 1 | Platter of the current command |
| hs_addr | output | 6 | Head (bit 5) and sector (bits 4..0) |
| addr_fault | input | 4 | Faults from the external address checker |
| drive_fault | input | 1 | Drive not usable |
| drive_wprot | input | 1 | Drive write protected |
| dma_active | input | 1 | Channel has more data to move |
| dma_stop | output | 1 | Stop pulse to the channel on error |
| dma_rvalid | output | 1 | Read byte valid toward the channel |
| dma_rdata | output | 8 | Read byte toward the channel |
| disk_rvalid | input | 1 | Medium supplies a read byte |
| disk_rdata | input | 8 | Read byte from the medium |
| dma_wvalid | input | 1 | Channel write byte valid |
| dma_wdata | input | 8 | Channel write byte |
| dma_wend | input | 1 | Channel's last byte for this sector |
| disk_wvalid | output | 1 | Write byte valid toward the medium |
| disk_wdata | output | 8 | Write byte toward the medium |
| irq | output | 1 | Unmaskable completion interrupt pulse |

## Verification
Read check is run against a table of fault patterns: none, each address fault alone, drive fault, and a mix. This separates the status bit each fault lands in, the examine summary, and whether the channel is stopped. Transfers are tried with a single read sector that is partly backed by the medium, which separates real bytes from zero fill. A read is also run across two sectors starting at sector 23, which exposes the head toggle and the rescheduling. A short write with a ten-byte tail shows whether padding repeats the final byte or something else. Directed cases cover a busy drive, a non-idle controller, illegal codes, a missing channel and write protect, which tell ignored commands apart from accepted ones.

// File: rtl/disk_seq.sv
`timescale 1ns/1ps
module disk_seq #(
  parameter int NDRV         = 4,
  parameter int ROT_PERIOD   = 16,
  parameter int SECTOR_BYTES = 256,
  parameter int SECTORS      = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           host_op,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  input  logic [NDRV-1:0]      drive_busy,
  output logic [((NDRV>1)?$clog2(NDRV):1)-1:0] sel_unit,
  output logic                 platter,
  output logic [5:0]           hs_addr,
  input  logic [3:0]           addr_fault,
  input  logic                 drive_fault,
  input  logic                 drive_wprot,
  input  logic                 dma_active,
  output logic                 dma_stop,
  output logic                 dma_rvalid,
  output logic [7:0]           dma_rdata,
  input  logic                 disk_rvalid,
  input  logic [7:0]           disk_rdata,
  input  logic                 dma_wvalid,
  input  logic [7:0]           dma_wdata,
  input  logic                 dma_wend,
  output logic                 disk_wvalid,
  output logic [7:0]           disk_wdata,
  output logic                 irq
);
  localparam int UW = (NDRV > 1) ? $clog2(NDRV) : 1;
  localparam int TW = $clog2(ROT_PERIOD + 1);
  localparam int CW = $clog2(SECTOR_BYTES + 1);
  localparam int SW = $clog2(SECTORS);
  localparam logic [2:0] OP_SEL = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3, OP_SS = 3'd4, OP_OC = 3'd5;
  localparam logic [7:0] ST_BUSY = 8'h08, ST_IDLE = 8'h02, ST_DTE = 8'h01;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER} st_t;

  st_t           st;
  logic [7:0]    sta, dbuf;
  logic [2:0]    cmd;
  logic [UW-1:0] svun;
  logic          svplat;
  logic [5:0]    hdsc;
  logic [TW-1:0] pre, tmr;
  logic [SW-1:0] rot;
  logic [CW-1:0] cnt;
  logic          fill;

  wire       idle     = sta[1];
  wire       is_cmd   = host_op == OP_OC;
  wire [3:0] cfn      = host_wdata[3:0];
  wire       clr      = is_cmd && cfn[3];
  wire       accept   = is_cmd && !cfn[3] && idle && !drive_busy[svun];
  wire       legal    = cfn[2:0] == 3'd1 || cfn[2:0] == 3'd2 || cfn[2:0] == 3'd3;
  wire       is_rd    = cmd == 3'd1;
  wire       is_wr    = cmd == 3'd2;
  wire [7:0] fflags   = {addr_fault, 3'b000, drive_fault | (is_wr & drive_wprot)};
  wire [7:0] rbyte    = disk_rvalid ? disk_rdata : 8'h00;
  wire [7:0] wbyte    = fill ? dbuf : dma_wdata;
  wire       byte_go  = st == S_XFER && (is_rd || (is_wr && (fill || dma_wvalid)));
  wire       last     = byte_go && cnt == CW'(SECTOR_BYTES - 1);

  assign sel_unit    = svun;
  assign hs_addr     = hdsc;
  assign dma_rvalid  = st == S_XFER && is_rd;
  assign dma_rdata   = rbyte;
  assign disk_wvalid = st == S_XFER && is_wr && (fill || dma_wvalid);
  assign disk_wdata  = wbyte;

  always_comb begin
    case (host_op)
      OP_RD:   host_rdata = idle ? 8'(rot) : dbuf;
      OP_SS:   host_rdata = {sta[7:3], |sta[7:4], sta[1:0]};
      default: host_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      rot <= '0;
    end else if (pre == TW'(ROT_PERIOD - 1)) begin
      pre <= '0;
      rot <= (int'(rot) == SECTORS - 1) ? '0 : rot + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st <= S_IDLE;  sta <= ST_BUSY | ST_IDLE;  cmd <= '0;
      svun <= '0;  svplat <= 1'b0;  platter <= 1'b0;
      dbuf <= '0;  hdsc <= '0;  tmr <= '0;  cnt <= '0;  fill <= 1'b0;
      irq <= 1'b0;  dma_stop <= 1'b0;
    end else begin
      irq      <= 1'b0;
      dma_stop <= 1'b0;
      case (host_op)
        OP_SEL: if (idle) begin
          svun   <= host_wdata[UW-1:0];
          svplat <= host_wdata[7];
        end
        OP_RD: if (!idle) sta[3] <= 1'b1;
        OP_WR: if (idle) hdsc <= host_wdata[5:0];
               else begin
                 sta[3] <= 1'b1;
                 dbuf   <= host_wdata;
               end
        OP_OC: if (accept) begin
          cmd     <= cfn[2:0];
          sta     <= (cfn[2:0] == 3'd2) ? 8'h00 : ST_BUSY;
          platter <= svplat;
          if (legal) begin
            st  <= S_WAIT;
            tmr <= TW'(ROT_PERIOD - 1);
          end
        end
        default: ;
      endcase

      case (st)
        S_WAIT: if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            cnt  <= '0;
            fill <= 1'b0;
            if (cmd == 3'd3 || (dma_active && |fflags)) begin
              sta      <= (sta | ST_IDLE | fflags) & ~ST_BUSY;
              irq      <= 1'b1;
              dma_stop <= |fflags;
              st       <= S_IDLE;
            end else if (!dma_active) begin
              sta <= (sta | ST_IDLE | ST_DTE) & ~ST_BUSY;
              irq <= 1'b1;
              st  <= S_IDLE;
            end else begin
              st <= S_XFER;
            end
          end
        S_XFER: begin
          if (is_wr && dma_wend) fill <= 1'b1;
          if (byte_go) begin
            cnt  <= cnt + 1'b1;
            dbuf <= is_rd ? rbyte : wbyte;
          end
          if (last) begin
            cnt  <= '0;
            fill <= 1'b0;
            if (int'(hdsc[4:0]) + 1 < SECTORS) hdsc <= hdsc + 1'b1;
            else hdsc <= {~hdsc[5], 5'b00000};
            if (dma_active) begin
              st  <= S_WAIT;
              tmr <= TW'(ROT_PERIOD - 1);
            end else begin
              sta <= (sta | ST_IDLE) & ~ST_BUSY;
              irq <= 1'b1;
              st  <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/disk_seq_chk.sv
`timescale 1ns/1ps
module disk_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       dma_stop,
  input logic [7:0] sta,
  input logic       dma_rvalid,
  input logic       disk_wvalid,
  input logic [2:0] host_op,
  input logic [7:0] host_rdata
);
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R10
  AST_STOP_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n) dma_stop |-> irq); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (sta[1] && !sta[3])); // R10
  AST_EXAMINE: assert property (@(posedge clk) disable iff (!rst_n) (host_op == 3'd4) |-> (host_rdata[2] == |host_rdata[7:4])); // R2
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n) !(dma_rvalid && disk_wvalid)); // R7
  AST_XFER_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (dma_rvalid || disk_wvalid) |-> !sta[1]); // R5
endmodule

bind disk_seq disk_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .dma_stop(dma_stop), .sta(sta),
  .dma_rvalid(dma_rvalid), .disk_wvalid(disk_wvalid),
  .host_op(host_op), .host_rdata(host_rdata)
);

// File: tb/disk_seq_tb_top.sv
`timescale 1ns/1ps
module disk_seq_tb_top;
  localparam int ROT = 16;
  localparam int SB  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] host_op = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [3:0] drive_busy = '0;
  logic [1:0] sel_unit;
  logic platter;
  logic [5:0] hs_addr;
  logic [3:0] addr_fault = '0;
  logic drive_fault = 1'b0, drive_wprot = 1'b0, dma_active = 1'b0;
  logic dma_stop, dma_rvalid, disk_wvalid, irq;
  logic [7:0] dma_rdata, disk_wdata;
  logic disk_rvalid, dma_wvalid, dma_wend;
  logic [7:0] disk_rdata, dma_wdata;

  int nchk = 0, nfail = 0;
  int irq_cnt = 0, stop_cnt = 0;
  int rcount = 0, wcount = 0, rd_bad = 0, wr_bad = 0;
  int rdrop = 1, wdrop = 1;
  bit done_flag = 0;

  always #10 clk = ~clk;

  assign disk_rvalid = rcount < 200;
  assign disk_rdata  = 8'(rcount) ^ 8'h5A;
  assign dma_wvalid  = wcount < 10;
  assign dma_wdata   = 8'h30 + 8'(wcount);
  assign dma_wend    = wcount == 9;

  disk_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_op(host_op), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .drive_busy(drive_busy), .sel_unit(sel_unit),
    .platter(platter), .hs_addr(hs_addr), .addr_fault(addr_fault),
    .drive_fault(drive_fault), .drive_wprot(drive_wprot), .dma_active(dma_active),
    .dma_stop(dma_stop), .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata),
    .disk_rvalid(disk_rvalid), .disk_rdata(disk_rdata), .dma_wvalid(dma_wvalid),
    .dma_wdata(dma_wdata), .dma_wend(dma_wend), .disk_wvalid(disk_wvalid),
    .disk_wdata(disk_wdata), .irq(irq)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (dma_stop) stop_cnt++;
    if (dma_rvalid) begin
      if (dma_rdata !== ((rcount % SB) < 200 && rcount < 200 ? 8'(rcount) ^ 8'h5A : 8'h00)) rd_bad++;
      rcount++;
      if (rcount >= rdrop) dma_active = 1'b0;
    end
    if (disk_wvalid) begin
      if (disk_wdata !== (wcount < 10 ? 8'h30 + 8'(wcount) : 8'h39)) wr_bad++;
      wcount++;
      if (wcount >= wdrop) dma_active = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    host_op = op;
    host_wdata = d;
    #1 rd = host_rdata;
    @(negedge clk);
    host_op = 3'd0;
  endtask

  task automatic sense(output logic [7:0] s);
    do_op(3'd4, 8'h00, s);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {addr_fault, drive_fault, expected status, expected stop}
  localparam logic [13:0] RC_VEC [7] = '{
    {4'h0, 1'b0, 8'h02, 1'b0},
    {4'h8, 1'b0, 8'h86, 1'b1},
    {4'h4, 1'b0, 8'h46, 1'b1},
    {4'h2, 1'b0, 8'h26, 1'b1},
    {4'h1, 1'b0, 8'h16, 1'b1},
    {4'h0, 1'b1, 8'h03, 1'b1},
    {4'hC, 1'b1, 8'hC7, 1'b1}
  };

  initial begin
    logic [7:0] r, a;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    sense(r);
    chk("R1 reset status", r, 8'h0A);
    chk("R1 reset unit", sel_unit, 0);
    chk("R1 reset hs", hs_addr, 0);
    chk("R1 reset platter", platter, 0);
    chk("R1 reset irq", irq_cnt, 0);

    do_op(3'd2, 0, a);
    chk("R3 sector range", a < 24, 1);
    wait_cyc(46);
    do_op(3'd2, 0, r);
    chk("R3 sector advance", r, (a + 3) % 24);
    wait_cyc(382);
    do_op(3'd2, 0, r);
    chk("R3 sector wrap", r, (a + 3) % 24);
    do_op(3'd3, 8'hFF, r);
    chk("R3 idle write loads hs", hs_addr, 6'h3F);

    for (int i = 0; i < 7; i++) begin
      do_op(3'd5, 8'h08, r);
      do_op(3'd1, 8'h00, r);
      addr_fault  = RC_VEC[i][13:10];
      drive_fault = RC_VEC[i][9];
      irq_cnt = 0; stop_cnt = 0;
      do_op(3'd5, 8'h03, r);
      wait_cyc(ROT + 4);
      sense(r);
      chk("R6 read check status", r, RC_VEC[i][8:1]);
      chk("R10 stop on error", stop_cnt, RC_VEC[i][0]);
      chk("R10 irq once", irq_cnt, 1);
      addr_fault = '0; drive_fault = 1'b0;
    end

    do_op(3'd5, 8'h08, r);
    do_op(3'd1, 8'h02, r);
    drive_busy = 4'b0100;
    irq_cnt = 0;
    do_op(3'd5, 8'h03, r);
    wait_cyc(ROT + 4);
    sense(r);
    chk("R4 busy drive ignored", r, 8'h0A);
    chk("R4 busy drive no irq", irq_cnt, 0);
    drive_busy = '0;

    do_op(3'd5, 8'h05, r);
    sense(r);
    chk("R5 illegal code status", r, 8'h08);
    wait_cyc(ROT * 3);
    chk("R5 illegal code no completion", irq_cnt, 0);
    do_op(3'd5, 8'h03, r);
    wait_cyc(ROT + 4);
    sense(r);
    chk("R4 non-idle ignored", r, 8'h08);
    chk("R4 non-idle no irq", irq_cnt, 0);
    do_op(3'd1, 8'h03, r);
    chk("R13 select ignored when busy", sel_unit, 2);
    do_op(3'd5, 8'h0F, r);
    sense(r);
    chk("R1 clear command status", r, 8'h0A);
    chk("R1 clear command unit", sel_unit, 0);

    do_op(3'd1, 8'h00, r);
    irq_cnt = 0; stop_cnt = 0;
    do_op(3'd5, 8'h02, r);
    sense(r);
    chk("R5 write accept status", r, 8'h00);
    do_op(3'd3, 8'h77, r);
    sense(r);
    chk("R12 data write sets busy", r, 8'h08);
    do_op(3'd2, 8'h00, r);
    chk("R12 data read returns buffer", r, 8'h77);
    wait_cyc(ROT + 4);
    sense(r);
    chk("R11 no channel status", r, 8'h03);
    chk("R11 no channel no stop", stop_cnt, 0);
    chk("R11 no channel irq", irq_cnt, 1);

    drive_wprot = 1'b1; dma_active = 1'b1;
    stop_cnt = 0; wcount = 0; wdrop = 1000;
    do_op(3'd5, 8'h02, r);
    wait_cyc(ROT + 4);
    sense(r);
    chk("R6 write protect status", r, 8'h03);
    chk("R6 write protect stop", stop_cnt, 1);
    chk("R6 write protect no bytes", wcount, 0);
    drive_wprot = 1'b0; dma_active = 1'b0;

    do_op(3'd5, 8'h08, r);
    do_op(3'd1, 8'h81, r);
    do_op(3'd3, 8'h05, r);
    rcount = 0; rd_bad = 0; rdrop = 1; irq_cnt = 0; stop_cnt = 0;
    dma_active = 1'b1;
    do_op(3'd5, 8'h01, r);
    chk("R13 platter latched", platter, 1);
    chk("R13 unit latched", sel_unit, 1);
    wait_cyc(ROT + SB + 8);
    chk("R7 read byte count", rcount, SB);
    chk("R7 read data and zero fill", rd_bad, 0);
    sense(r);
    chk("R10 read done status", r, 8'h02);
    chk("R10 read no stop", stop_cnt, 0);
    chk("R9 hs advance", hs_addr, 6'h06);

    do_op(3'd3, 8'h17, r);
    rcount = 0; rd_bad = 0; rdrop = SB + 1; irq_cnt = 0;
    dma_active = 1'b1;
    do_op(3'd5, 8'h01, r);
    wait_cyc(2 * (ROT + SB) + 8);
    chk("R9 two sector bytes", rcount, 2 * SB);
    chk("R9 two sector data", rd_bad, 0);
    chk("R9 head toggle wrap", hs_addr, 6'h21);
    chk("R9 single irq", irq_cnt, 1);

    do_op(3'd3, 8'h00, r);
    wcount = 0; wr_bad = 0; wdrop = 1; irq_cnt = 0;
    dma_active = 1'b1;
    do_op(3'd5, 8'h02, r);
    wait_cyc(ROT + SB + 8);
    chk("R8 write byte count", wcount, SB);
    chk("R8 write data and padding", wr_bad, 0);
    sense(r);
    chk("R8 write done status", r, 8'h02);
    chk("R8 write irq", irq_cnt, 1);

    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      done_flag = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule